// File: doc/BRIEF.md
# Multi-Lane Startup Deskew Aligner

This block lines up byte streams arriving on many serial receive lanes. Each lane is driven by its own transmitter, and all transmitters run from one shared frequency reference. Because of that shared reference, the lane-to-lane skew stays fixed while the system is powered. The skew can still change from one reset to the next, so the block measures it again after every reset and after every restart request.

During a search, every transmitter sends a reserved marker byte at the same moment. The aligner notes how many cycles after the earliest marker each lane's marker arrives. It then gives each early lane just enough extra delay that all lanes match the latest one. Bytes that arrived ahead of the latest lane are dropped. The per-lane delays stay frozen until the next restart, and the block then presents one aligned word per cycle with a valid strobe. Skew that is too large, or a marker that never arrives, raises a sticky error flag instead. No skip-code insertion or removal is done, and drift between clocks is not tracked.

Top module: `lane_deskew`

## Requirements
- R1: A marker on lane i is byte 8'hBC on rx_data[8i+7:8i] with rx_k[i] high. The same byte with rx_k[i] low is treated as ordinary data and starts nothing.
- R2: In SEARCH, a lane's offset is the number of cycles from the first cycle in which any lane showed a marker to the first cycle in which that lane showed its own. aligned goes high in the cycle after the last lane's first marker.
- R3: When aligned, every lane has the same total delay. The first word with data_valid high holds, on every lane, the byte each transmitter sent right after its marker. data_valid rises one cycle after aligned.
- R4: While aligned, the per-lane delays are frozen. A later marker on any lane changes neither the alignment nor aligned, and later words keep carrying each transmitter's stream in order.
- R5: If the offset spread reaches DEPTH, align_error rises DEPTH cycles after the first marker and aligned stays low. A spread of DEPTH-1 still aligns.
- R6: If SEARCH does not see markers on all lanes within its first TIMEOUT cycles, align_error rises in the cycle TIMEOUT+1 after SEARCH was entered.
- R7: align_error is sticky until align_req or rst, and aligned is never high together with it.
- R8: Whenever data_valid is low, out_data is all zeros. This covers IDLE, SEARCH and the error state.
- R9: align_req, sampled at a clock edge, moves the block to IDLE for one cycle and then to SEARCH. It clears align_error, and it drops aligned and data_valid in the cycle that follows.
- R10: Under rst, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset |
| align_req | input | 1 | Restart the skew measurement |
| rx_data | input | 8*NUM_LANES | Received bytes, lane i at bits 8i+7:8i |
| rx_k | input | NUM_LANES | Per-lane control-character flag |
| out_data | output | 8*NUM_LANES | Aligned bytes, same lane layout |
| data_valid | output | 1 | out_data holds an aligned word |
| aligned | output | 1 | Delays are locked |
| align_error | output | 1 | Sticky skew-too-large or marker-timeout flag |

## Verification
The bench builds the aligner with 4 lanes, a delay depth of 8 and a timeout of 32. With these values the skew limit, the timeout and the full range of per-lane delays can all be reached within a few dozen cycles per run. It sweeps 40 offset patterns over every delay value from 0 to 7, including patterns where the earliest lane is not lane 0 and where the spread is exactly DEPTH-1. The expected output word and the cycle in which aligned rises are worked out arithmetically from the injected offsets. Separate runs push the spread to DEPTH and withhold all markers, which exercises both error paths and the recovery through align_req.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_ALIGNED = 2'd2,
    ST_FAIL    = 2'd3
  } align_state_e;

  localparam logic [7:0] MARKER_BYTE = 8'hBC;
endpackage

// File: rtl/deskew_delay_line.sv
// Per-lane circular buffer with a variable read distance (0 = bypass).
module deskew_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] dly,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q;
  logic [AW-1:0] rd_addr;

  always_ff @(posedge clk) begin
    mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) wp_q <= '0;
    else     wp_q <= wp_q + 1'b1;
  end

  assign rd_addr = wp_q - dly;
  assign dout    = (dly == '0) ? din : mem[rd_addr];
endmodule

// File: rtl/deskew_ctrl.sv
// Search FSM: measures marker offsets, latches per-lane delays.
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 22,
  parameter int DEPTH     = 16,
  parameter int TIMEOUT   = 64,
  localparam int OW       = $clog2(DEPTH),
  localparam int TW       = $clog2(TIMEOUT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    align_req,
  input  logic [NUM_LANES-1:0]    mk_i,
  output align_state_e            state_o,
  output logic                    err_o,
  output logic [NUM_LANES*OW-1:0] delay_o
);
  localparam logic [OW-1:0] LAST_OFF = OW'(DEPTH - 1);
  localparam logic [TW-1:0] LAST_T   = TW'(TIMEOUT - 1);

  align_state_e         state_q, state_d;
  logic [NUM_LANES-1:0] seen_q;
  logic [OW-1:0]        off_q [NUM_LANES];
  logic [OW-1:0]        elapsed_q, cur_el, maxoff_q;
  logic [TW-1:0]        search_cnt_q;
  logic                 started_q, err_q;
  logic [NUM_LANES-1:0] mk_new;
  logic                 active, all_next;

  always_comb begin
    mk_new   = mk_i & ~seen_q;
    active   = started_q | (|mk_new);
    cur_el   = started_q ? elapsed_q : '0;
    all_next = &(seen_q | mk_i);
    state_d  = state_q;
    case (state_q)
      ST_IDLE:   state_d = ST_SEARCH;
      ST_SEARCH: begin
        if (all_next)
          state_d = ST_ALIGNED;
        else if ((active && cur_el == LAST_OFF) || search_cnt_q == LAST_T)
          state_d = ST_FAIL;
      end
      default:   state_d = state_q;
    endcase
    if (align_req) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      seen_q       <= '0;
      started_q    <= 1'b0;
      elapsed_q    <= '0;
      search_cnt_q <= '0;
      maxoff_q     <= '0;
      err_q        <= 1'b0;
      for (int i = 0; i < NUM_LANES; i++) off_q[i] <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        seen_q       <= '0;
        started_q    <= 1'b0;
        elapsed_q    <= '0;
        search_cnt_q <= '0;
      end else if (state_q == ST_SEARCH) begin
        search_cnt_q <= search_cnt_q + 1'b1;
        if (active) begin
          started_q <= 1'b1;
          elapsed_q <= cur_el + 1'b1;
        end
        for (int i = 0; i < NUM_LANES; i++) begin
          if (mk_new[i]) begin
            seen_q[i] <= 1'b1;
            off_q[i]  <= cur_el;
          end
        end
        if (state_d == ST_ALIGNED) maxoff_q <= cur_el;
      end
      if (align_req)
        err_q <= 1'b0;
      else if (state_q == ST_SEARCH && state_d == ST_FAIL)
        err_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_dly
    assign delay_o[g*OW +: OW] = maxoff_q - off_q[g];
  end

  assign state_o = state_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 22,
  parameter int DEPTH     = 16,
  parameter int TIMEOUT   = 64,
  localparam int OW       = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   align_req,
  input  logic [NUM_LANES*8-1:0] rx_data,
  input  logic [NUM_LANES-1:0]   rx_k,
  output logic [NUM_LANES*8-1:0] out_data,
  output logic                   data_valid,
  output logic                   aligned,
  output logic                   align_error
);
  logic [NUM_LANES-1:0]    mk;
  logic [NUM_LANES*OW-1:0] delay;
  logic [NUM_LANES*8-1:0]  dly_bytes;
  align_state_e            state;
  logic                    err;
  logic [NUM_LANES*8-1:0]  out_q;
  logic                    valid_q;

  deskew_ctrl #(
    .NUM_LANES(NUM_LANES),
    .DEPTH    (DEPTH),
    .TIMEOUT  (TIMEOUT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .align_req(align_req),
    .mk_i     (mk),
    .state_o  (state),
    .err_o    (err),
    .delay_o  (delay)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign mk[g] = rx_k[g] && (rx_data[g*8 +: 8] == MARKER_BYTE);

    deskew_delay_line #(
      .W    (8),
      .DEPTH(DEPTH)
    ) u_line (
      .clk (clk),
      .rst (rst),
      .din (rx_data[g*8 +: 8]),
      .dly (delay[g*OW +: OW]),
      .dout(dly_bytes[g*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (state == ST_ALIGNED && !align_req) begin
      out_q   <= dly_bytes;
      valid_q <= 1'b1;
    end else begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end
  end

  assign out_data    = out_q;
  assign data_valid  = valid_q;
  assign aligned     = (state == ST_ALIGNED);
  assign align_error = err;
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
  parameter int NUM_LANES = 22
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   align_req,
  input logic [NUM_LANES*8-1:0] out_data,
  input logic                   data_valid,
  input logic                   aligned,
  input logic                   align_error
);
  p_valid_after_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(aligned));

  p_zero_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> (out_data == '0));

  p_error_excludes_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    align_error |-> !aligned);

  p_error_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (align_error && !align_req) |=> align_error);

  p_req_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    align_req |=> (!aligned && !align_error && !data_valid));

  p_lock_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (aligned && !align_req) |=> aligned);
endmodule

bind lane_deskew lane_deskew_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .align_req  (align_req),
  .out_data   (out_data),
  .data_valid (data_valid),
  .aligned    (aligned),
  .align_error(align_error)
);

// File: tb/lane_deskew_test.sv
module lane_deskew_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int DP = 8;
  localparam int TO = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            align_req = 1'b0;
  logic [NL*8-1:0] rx_data = '0;
  logic [NL-1:0]   rx_k = '0;
  logic [NL*8-1:0] out_data;
  logic            data_valid, aligned, align_error;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int off_r [NL];
  bit act_r [NL];
  int base_r = 3;
  bit inj_r = 1'b0;
  int seed_r = 0;

  lane_deskew #(.NUM_LANES(NL), .DEPTH(DP), .TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .align_req(align_req),
    .rx_data(rx_data), .rx_k(rx_k),
    .out_data(out_data), .data_valid(data_valid),
    .aligned(aligned), .align_error(align_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] tx_byte(int lane, int tau);
    if (inj_r && lane == 0 && tau == 10) return 8'hBC;
    return 8'((lane*37 + tau*11 + seed_r) & 255);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Lane i sees the transmit stream delayed by off_r[i]; tau 0 is the marker.
  task automatic drive(int c);
    for (int i = 0; i < NL; i++) begin
      int tau;
      logic [7:0] b;
      logic k;
      tau = c - base_r - off_r[i];
      if (tau < 0 || (tau == 0 && !act_r[i])) begin
        k = 1'b0;  // R1: filler may be 8'hBC with k low
        b = (c % 3 == 0) ? 8'hBC : 8'((c*7 + i*5) & 255);
      end else if (tau == 0) begin
        k = 1'b1;
        b = 8'hBC;
      end else begin
        b = tx_byte(i, tau);
        k = inj_r && i == 0 && tau == 10;
      end
      rx_data[i*8 +: 8] = b;
      rx_k[i] = k;
    end
  endtask

  // mode 0: expected lock, 1: spread too large, 2: no markers
  task automatic run(int mode);
    int omax, omin, endc, lc, fb;
    logic [NL*8-1:0] exp;
    omax = off_r[0];
    omin = off_r[0];
    for (int i = 1; i < NL; i++) begin
      if (off_r[i] > omax) omax = off_r[i];
      if (off_r[i] < omin) omin = off_r[i];
    end
    lc = base_r + omax;
    fb = base_r + omin + DP;
    endc = (mode == 0) ? lc + 14 : (mode == 1) ? fb + 6 : TO + 6;
    @(negedge clk);
    align_req = 1'b1;
    drive(-1);
    for (int c = 0; c <= endc; c++) begin
      @(negedge clk);
      if (c == 0) begin
        chk("R9 aligned low in IDLE", 64'(aligned), 64'd0);
        chk("R9 error cleared", 64'(align_error), 64'd0);
        chk("R9 valid low in IDLE", 64'(data_valid), 64'd0);
      end
      if (mode == 0) begin
        chk("R5 no error within range", 64'(align_error), 64'd0);
        if (c <= lc) begin
          chk("R2 aligned before last marker", 64'(aligned), 64'd0);
          chk("R8 valid low in search", 64'(data_valid), 64'd0);
          chk("R8 data zero in search", 64'(out_data), 64'd0);
        end else if (c == lc + 1) begin
          chk("R2 aligned after last marker", 64'(aligned), 64'd1);
          chk("R3 valid lags aligned", 64'(data_valid), 64'd0);
        end else begin
          for (int i = 0; i < NL; i++) exp[i*8 +: 8] = tx_byte(i, c - lc - 1);
          chk("R4 aligned held", 64'(aligned), 64'd1);
          chk("R3 valid", 64'(data_valid), 64'd1);
          chk("R3 R1 aligned word", 64'(out_data), 64'(exp));
        end
      end else begin
        chk("R7 aligned low", 64'(aligned), 64'd0);
        chk("R8 valid low", 64'(data_valid), 64'd0);
        chk("R8 data zero", 64'(out_data), 64'd0);
        if (mode == 1)
          chk("R5 R7 spread error", 64'(align_error), 64'(c >= fb));
        else
          chk("R6 R7 timeout error", 64'(align_error), 64'(c > TO));
      end
      align_req = 1'b0;
      drive(c);
    end
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin off_r[i] = 0; act_r[i] = 1'b1; end
    repeat (3) @(negedge clk);
    chk("R10 reset aligned", 64'(aligned), 64'd0);
    chk("R10 reset valid", 64'(data_valid), 64'd0);
    chk("R10 reset error", 64'(align_error), 64'd0);
    chk("R10 reset data", 64'(out_data), 64'd0);
    rst = 1'b0;

    // Sweep offsets 0..DP-1 across lanes, with late-marker injection (R4)
    for (int s = 0; s < 40; s++) begin
      for (int i = 0; i < NL; i++) off_r[i] = (s*(2*i+1) + 3*i) % DP;
      inj_r = (s % 4 == 0);
      seed_r = s*13;
      run(0);
    end
    inj_r = 1'b0;
    // R5: spread of DP-1 still locks
    off_r[0] = 0; off_r[1] = DP-1; off_r[2] = 3; off_r[3] = DP-1;
    run(0);
    // R5: spread of DP fails
    off_r[0] = 2; off_r[1] = 2 + DP; off_r[2] = 4; off_r[3] = 5;
    run(1);
    // R6: no markers at all
    for (int i = 0; i < NL; i++) act_r[i] = 1'b0;
    run(2);
    // R9: recovery after error
    for (int i = 0; i < NL; i++) act_r[i] = 1'b1;
    off_r[0] = 5; off_r[1] = 0; off_r[2] = 2; off_r[3] = 7;
    seed_r = 99;
    run(0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule